// File: doc/BRIEF.md
# Sliding 3x3 Window Line Buffer

The block accepts a raster pixel stream, one pixel every clock, together with a frame-start marker and a row-start marker. It keeps the two previous image rows in circular line memories. Every cycle it presents the 3x3 neighbourhood that ends at the most recently accepted pixel as nine parallel outputs. A downstream filter can then consume one complete window per clock.

Each line memory is read at the current column and rewritten at that same column in the same cycle, so the old content comes out before it is overwritten. The pixel evicted from the first line memory is written into the second. The frame and row markers pass through the same one-cycle register stage as the newest window pixel, so they stay aligned with the window. Window taps that would reach above the top row or left of column 0 show a fixed fill value. Row length, frame height, pixel width and fill value are parameters.

Output `nb_kj` holds the pixel k rows above and j columns left of the newest pixel.

Top module: `sliding_window_linebuf`

## Requirements
- R1: While reset is held and after it is released with no pixel yet accepted, all nine window outputs equal the fill value and both sync outputs are 0.
- R2: After each clock edge, `nb_00` equals the `pix_i` value sampled at that edge.
- R3: `nb_01` and `nb_02` equal the pixels of the same row one and two columns to the left of the newest pixel.
- R4: `nb_10` and `nb_20` equal the pixels in the same column one and two rows above. These come from read-before-write line memories addressed by the column.
- R5: When the newest pixel has row >= 2 and column >= 2, all nine outputs equal the corresponding image pixels.
- R6: Any tap `nb_kj` with row < k or column < j of the newest pixel shows `FILL_VAL` (default 0).
- R7: A pixel sampled with `fsync_i` = 1 is placed at row 0, column 0, whatever the state of `rsync_i`.
- R8: A pixel sampled with `rsync_i` = 1 and `fsync_i` = 0 is placed at column 0 of the next row.
- R9: Without a marker, the column advances by 1. After column COLS-1 it wraps to 0 and the row advances.
- R10: `fsync_o` and `rsync_o` equal `fsync_i` and `rsync_i` delayed by one clock, aligned with `nb_00`.
- R11: The row number wraps from ROWS-1 back to 0 when it advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame start; marks row 0, column 0 |
| rsync_i | input | 1 | Row start; marks column 0 of the next row |
| pix_i | input | PIX_W | Incoming pixel |
| fsync_o | output | 1 | Frame marker aligned with the window |
| rsync_o | output | 1 | Row marker aligned with the window |
| nb_00 | output | PIX_W | Newest pixel |
| nb_01 | output | PIX_W | Same row, one column left |
| nb_02 | output | PIX_W | Same row, two columns left |
| nb_10 | output | PIX_W | One row up, same column |
| nb_11 | output | PIX_W | One row up, one column left |
| nb_12 | output | PIX_W | One row up, two columns left |
| nb_20 | output | PIX_W | Two rows up, same column |
| nb_21 | output | PIX_W | Two rows up, one column left |
| nb_22 | output | PIX_W | Two rows up, two columns left |

## Verification
The bench targets the first two columns of each row. A design that fails to mask the left border there would leak the previous row's tail pixels into the left taps. It also targets the first two rows of each frame, where a missing top mask would expose stale memory from the prior frame. Frames alternate between explicit row markers and natural column wrap, and some run past the frame height. A faulty wrap or marker priority would therefore shift every vertical tap by a row or a column. Narrow frames followed by full-width ones show whether the memories really return the old value before the write; a write-first memory would repeat the current row in the upper taps.

// File: rtl/lbw_pkg.sv
package lbw_pkg;
   // Window edge length; the block is built for a square 3x3 neighbourhood
   localparam int WIN = 3;
   // Number of line memories needed to hold the rows above the newest one
   localparam int LINES = WIN - 1;
endpackage

// File: rtl/lbw_pos_track.sv
module lbw_pos_track #(
   parameter int COLS  = 752,
   parameter int ROWS  = 480,
   parameter int COL_W = $clog2(COLS),
   parameter int ROW_W = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync_i,
   input  logic             rsync_i,
   output logic [COL_W-1:0] cur_col_o,
   output logic [COL_W-1:0] pos_col_o,
   output logic [ROW_W-1:0] pos_row_o
);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

   logic [COL_W-1:0] col_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_d;
   logic [ROW_W-1:0] row_d;
   logic             line_end;
   logic             next_line;

   assign line_end  = (col_q == LAST_COL);
   assign next_line = rsync_i | line_end;

   // position of the pixel presented in this cycle
   always_comb begin
      if (fsync_i) begin
         col_d = '0;
         row_d = '0;
      end else if (next_line) begin
         col_d = '0;
         row_d = (row_q == LAST_ROW) ? '0 : row_q + 1'b1;
      end else begin
         col_d = col_q + 1'b1;
         row_d = row_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else begin
         col_q <= col_d;
         row_q <= row_d;
      end
   end

   assign cur_col_o = col_d;
   assign pos_col_o = col_q;
   assign pos_row_o = row_q;
endmodule

// File: rtl/lbw_line_mem.sv
module lbw_line_mem #(
   parameter int W     = 8,
   parameter int DEPTH = 752,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic [AW-1:0] addr_i,
   input  logic [W-1:0]  wdata_i,
   output logic [W-1:0]  old_o
);
   logic [W-1:0] store [DEPTH];

   // read-before-write: the stored value leaves before the new one lands
   assign old_o = store[addr_i];

   always_ff @(posedge clk) begin
      store[addr_i] <= wdata_i;
   end
endmodule

// File: rtl/lbw_tap_row.sv
module lbw_tap_row #(
   parameter int W = 8,
   parameter int N = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [W-1:0]        head_i,
   output logic [N-1:0][W-1:0] taps_o
);
   logic [N-1:0][W-1:0] stage;

   assign stage[0] = head_i;

   for (genvar s = 1; s < N; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage[s] <= '0;
         else        stage[s] <= stage[s-1];
      end
   end

   assign taps_o = stage;
endmodule

// File: rtl/sliding_window_linebuf.sv
module sliding_window_linebuf
   import lbw_pkg::*;
#(
   parameter int              PIX_W       = 8,
   parameter int              COLS        = 752,
   parameter int              ROWS        = 480,
   parameter logic [PIX_W-1:0] FILL_VAL   = '0,
   parameter bit              BORDER_FILL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync_i,
   input  logic             rsync_i,
   input  logic [PIX_W-1:0] pix_i,
   output logic             fsync_o,
   output logic             rsync_o,
   output logic [PIX_W-1:0] nb_00,
   output logic [PIX_W-1:0] nb_01,
   output logic [PIX_W-1:0] nb_02,
   output logic [PIX_W-1:0] nb_10,
   output logic [PIX_W-1:0] nb_11,
   output logic [PIX_W-1:0] nb_12,
   output logic [PIX_W-1:0] nb_20,
   output logic [PIX_W-1:0] nb_21,
   output logic [PIX_W-1:0] nb_22
);
   localparam int COL_W = $clog2(COLS);
   localparam int ROW_W = $clog2(ROWS);

   // elaboration checks on the parameter set
   if (PIX_W < 1) begin : g_bad_width
      $error("sliding_window_linebuf: PIX_W must be at least 1");
   end
   if (COLS < WIN) begin : g_bad_cols
      $error("sliding_window_linebuf: COLS must cover the window width");
   end
   if (ROWS < WIN) begin : g_bad_rows
      $error("sliding_window_linebuf: ROWS must cover the window height");
   end

   logic [COL_W-1:0] cur_col;
   logic [COL_W-1:0] pos_col;
   logic [ROW_W-1:0] pos_row;

   lbw_pos_track #(
      .COLS (COLS),
      .ROWS (ROWS),
      .COL_W(COL_W),
      .ROW_W(ROW_W)
   ) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .fsync_i  (fsync_i),
      .rsync_i  (rsync_i),
      .cur_col_o(cur_col),
      .pos_col_o(pos_col),
      .pos_row_o(pos_row)
   );

   // feed[0] is the live pixel, feed[k] the pixel evicted from line memory k
   logic [PIX_W-1:0] feed [WIN];
   logic [PIX_W-1:0] head_q [WIN];

   assign feed[0] = pix_i;

   for (genvar k = 1; k <= LINES; k++) begin : g_line
      lbw_line_mem #(
         .W    (PIX_W),
         .DEPTH(COLS),
         .AW   (COL_W)
      ) u_mem (
         .clk    (clk),
         .addr_i (cur_col),
         .wdata_i(feed[k-1]),
         .old_o  (feed[k])
      );
   end

   logic [WIN-1:0][WIN-1:0][PIX_W-1:0] raw;
   logic [WIN-1:0][WIN-1:0][PIX_W-1:0] win;

   for (genvar k = 0; k < WIN; k++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) head_q[k] <= '0;
         else        head_q[k] <= feed[k];
      end

      lbw_tap_row #(
         .W(PIX_W),
         .N(WIN)
      ) u_taps (
         .clk   (clk),
         .rst_n (rst_n),
         .head_i(head_q[k]),
         .taps_o(raw[k])
      );

      for (genvar j = 0; j < WIN; j++) begin : g_col
         localparam logic [ROW_W-1:0] KR = ROW_W'(k);
         localparam logic [COL_W-1:0] JC = COL_W'(j);
         if (BORDER_FILL) begin : g_fill
            assign win[k][j] = ((pos_row < KR) || (pos_col < JC)) ? FILL_VAL : raw[k][j];
         end else begin : g_pass
            assign win[k][j] = raw[k][j];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsync_o <= 1'b0;
         rsync_o <= 1'b0;
      end else begin
         fsync_o <= fsync_i;
         rsync_o <= rsync_i;
      end
   end

   assign nb_00 = win[0][0];
   assign nb_01 = win[0][1];
   assign nb_02 = win[0][2];
   assign nb_10 = win[1][0];
   assign nb_11 = win[1][1];
   assign nb_12 = win[1][2];
   assign nb_20 = win[2][0];
   assign nb_21 = win[2][1];
   assign nb_22 = win[2][2];
endmodule

// File: rtl/lbw_checker.sv
module lbw_checker #(
   parameter int               PIX_W    = 8,
   parameter logic [PIX_W-1:0] FILL_VAL = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fsync_i,
   input logic             rsync_i,
   input logic [PIX_W-1:0] pix_i,
   input logic             fsync_o,
   input logic             rsync_o,
   input logic [PIX_W-1:0] nb_00,
   input logic [PIX_W-1:0] nb_01,
   input logic [PIX_W-1:0] nb_02,
   input logic [PIX_W-1:0] nb_10,
   input logic [PIX_W-1:0] nb_11,
   input logic [PIX_W-1:0] nb_12,
   input logic [PIX_W-1:0] nb_20,
   input logic [PIX_W-1:0] nb_21,
   input logic [PIX_W-1:0] nb_22
);
   AST_NEWEST_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> nb_00 == $past(pix_i)); // R2

   AST_FSYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> fsync_o == $past(fsync_i)); // R10

   AST_RSYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> rsync_o == $past(rsync_i)); // R10

   AST_FRAME_TOP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      fsync_o |-> (nb_01 == FILL_VAL && nb_02 == FILL_VAL && nb_10 == FILL_VAL &&
                   nb_11 == FILL_VAL && nb_12 == FILL_VAL && nb_20 == FILL_VAL &&
                   nb_21 == FILL_VAL && nb_22 == FILL_VAL)); // R7

   AST_ROW_LEFT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      rsync_o |-> (nb_01 == FILL_VAL && nb_02 == FILL_VAL && nb_11 == FILL_VAL &&
                   nb_12 == FILL_VAL && nb_21 == FILL_VAL && nb_22 == FILL_VAL)); // R8
endmodule

bind sliding_window_linebuf lbw_checker #(
   .PIX_W   (PIX_W),
   .FILL_VAL(FILL_VAL)
) u_lbw_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .fsync_i(fsync_i),
   .rsync_i(rsync_i),
   .pix_i  (pix_i),
   .fsync_o(fsync_o),
   .rsync_o(rsync_o),
   .nb_00  (nb_00),
   .nb_01  (nb_01),
   .nb_02  (nb_02),
   .nb_10  (nb_10),
   .nb_11  (nb_11),
   .nb_12  (nb_12),
   .nb_20  (nb_20),
   .nb_21  (nb_21),
   .nb_22  (nb_22)
);

// File: tb/sliding_window_linebuf_tb_top.sv
`timescale 1ns/1ps
module sliding_window_linebuf_tb_top;
   localparam int PW   = 8;
   localparam int NC   = 6;
   localparam int NR   = 5;
   localparam int WN   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fs_i = 1'b0;
   logic          rs_i = 1'b0;
   logic [PW-1:0] px_i = '0;
   logic          fs_o, rs_o;
   logic [PW-1:0] o00, o01, o02, o10, o11, o12, o20, o21, o22;

   always #10 clk = ~clk;

   sliding_window_linebuf #(
      .PIX_W(PW),
      .COLS (NC),
      .ROWS (NR)
   ) dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .fsync_i(fs_i),
      .rsync_i(rs_i),
      .pix_i  (px_i),
      .fsync_o(fs_o),
      .rsync_o(rs_o),
      .nb_00(o00), .nb_01(o01), .nb_02(o02),
      .nb_10(o10), .nb_11(o11), .nb_12(o12),
      .nb_20(o20), .nb_21(o21), .nb_22(o22)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // bench image model and expected window
   int img [NR][NC];
   int m_col = 0;
   int m_row = 0;
   int exp_w [WN][WN];
   bit exp_fs, exp_rs;
   bit have_exp = 1'b0;

   function automatic int act_tap(input int k, input int j);
      logic [PW-1:0] v;
      case (k*3 + j)
         0: v = o00; 1: v = o01; 2: v = o02;
         3: v = o10; 4: v = o11; 5: v = o12;
         6: v = o20; 7: v = o21; default: v = o22;
      endcase
      return int'(v);
   endfunction

   function automatic string tap_req(input int k, input int j, input int r, input int c);
      if (r < k || c < j)  return "R6";
      if (k == 0 && j == 0) return "R2";
      if (k == 0)          return "R3";
      if (j == 0)          return "R4";
      return "R5";
   endfunction

   int exp_r, exp_c;

   task automatic check_pending();
      for (int k = 0; k < WN; k++) begin
         for (int j = 0; j < WN; j++) begin
            n_tests++;
            if (act_tap(k, j) != exp_w[k][j]) begin
               n_fail++;
               $display("FAIL %s tap %0d%0d at row %0d col %0d: got %0d expected %0d",
                        tap_req(k, j, exp_r, exp_c), k, j, exp_r, exp_c,
                        act_tap(k, j), exp_w[k][j]);
            end
         end
      end
      n_tests++; // R10 markers aligned with the newest pixel
      if (fs_o !== exp_fs || rs_o !== exp_rs) begin
         n_fail++;
         $display("FAIL R10 sync: got fs=%0b rs=%0b expected fs=%0b rs=%0b",
                  fs_o, rs_o, exp_fs, exp_rs);
      end
   endtask

   // one pixel per call; model follows R7, R8, R9 and R11
   task automatic step(input int p, input bit f, input bit r);
      int cc, cr;
      @(negedge clk);
      if (have_exp) check_pending();
      fs_i = f; rs_i = r; px_i = PW'(p);
      if (f) begin
         cc = 0; cr = 0;                                  // R7
      end else if (r || m_col == NC-1) begin
         cc = 0;                                          // R8, R9
         cr = (m_row == NR-1) ? 0 : m_row + 1;            // R11
      end else begin
         cc = m_col + 1; cr = m_row;
      end
      img[cr][cc] = p & 8'hFF;
      for (int k = 0; k < WN; k++)
         for (int j = 0; j < WN; j++)
            exp_w[k][j] = (cr < k || cc < j) ? 0 : img[cr-k][cc-j];
      exp_fs = f; exp_rs = r;
      exp_r = cr; exp_c = cc;
      m_col = cc; m_row = cr;
      have_exp = 1'b1;
   endtask

   task automatic flush();
      @(negedge clk);
      if (have_exp) check_pending();
      have_exp = 1'b0;
      fs_i = 1'b0; rs_i = 1'b0; px_i = '0;
   endtask

   // a frame of 'h' rows of length 'len'; markers either explicit or by wrap
   task automatic frame(input int len, input int h, input bit use_rs, input bit ramp);
      for (int r = 0; r < h; r++) begin
         for (int c = 0; c < len; c++) begin
            int p;
            p = ramp ? (r*16 + c + 1) : int'($urandom_range(255, 0));
            step(p, (r == 0 && c == 0), (c == 0) && (use_rs || len < NC));
         end
      end
   endtask

   initial begin
      void'($urandom(32'h1d5e_a0c3));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values
      n_tests++;
      if ({o00,o01,o02,o10,o11,o12,o20,o21,o22} != '0 || fs_o || rs_o) begin
         n_fail++;
         $display("FAIL R1 reset: window=%h fs=%0b rs=%0b expected all 0",
                  {o00,o01,o02,o10,o11,o12,o20,o21,o22}, fs_o, rs_o);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_tests++;
      if ({o00,o01,o02,o10,o11,o12,o20,o21,o22} != '0 || fs_o || rs_o) begin
         n_fail++;
         $display("FAIL R1 after release: window=%h expected all 0",
                  {o00,o01,o02,o10,o11,o12,o20,o21,o22});
      end
      // directed: known ramp frame with row markers (R3, R4, R5, R6, R8)
      frame(NC, NR, 1'b1, 1'b1);
      // directed: same frame relying on column wrap (R9)
      frame(NC, NR, 1'b0, 1'b1);
      // directed: narrow frame then a full one, read-before-write (R4, R8)
      frame(3, 4, 1'b1, 1'b1);
      frame(NC, 3, 1'b0, 1'b0);
      // directed: frame taller than ROWS, row wrap (R11)
      frame(NC, NR + 3, 1'b0, 1'b1);
      // constrained random frames
      for (int n = 0; n < 40; n++) begin
         int len, h;
         len = int'($urandom_range(NC, 3));
         h   = int'($urandom_range(NR + 2, 1));
         frame(len, h, 1'($urandom_range(1, 0)), 1'b0);
      end
      flush();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule